// File: doc/BRIEF.md
# Single-Cycle Load/Store Core

This block is a 32-bit processor core that finishes every instruction in one clock. It supports seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch when equal, and an absolute jump. Each cycle it fetches the word at the program counter and decodes it into a set of control points. It reads two registers, runs the ALU and, where the instruction calls for it, touches data memory. On the next clock edge it writes the result and the new program counter.

The core drives two memory ports outside the block. The first is an instruction port: an address goes out and an instruction word comes back. The second is a data port with an address, write data, a write strobe and read data. Both memories are read combinationally, in the same cycle. Data memory is written on the same clock edge that updates the core. An opcode outside the subset, and an R-format function code outside add and subtract, each run as a no-op.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter, and so `imem_addr`, to 0. While `rst` is high, no register is written and `dmem_we` stays low.
- R2: Apart from a taken branch or a jump, the program counter moves forward by 4 each clock.
- R3: An instruction has opcode bits [31:26] = 000000, rs in [25:21], rt in [20:16] and rd in [15:11]. With function bits [5:0] = 100000 it writes R[rs]+R[rt] into R[rd]. With function bits 100010 it writes R[rs]-R[rt] into R[rd]. Any other function code is a no-op.
- R4: Opcode 001101 writes R[rs] OR the zero-extended immediate [15:0] into R[rt].
- R5: Opcode 100011 reads data memory at R[rs] plus the sign-extended immediate and writes the value read into R[rt].
- R6: Opcode 101011 writes R[rt] to data memory at R[rs] plus the sign-extended immediate, and it writes no register.
- R7: Opcode 000100 compares R[rs] and R[rt] with a subtract. When the ALU result is zero, the next PC is PC+4 plus the sign-extended immediate times 4. Otherwise the next PC is PC+4.
- R8: Opcode 000010 sets the next PC to bits [31:28] of PC+4, followed by target bits [25:0], followed by 00.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: Any other opcode writes no register and no memory, and it advances the PC by 4.
- R11: An instruction that reads and writes the same register in one cycle reads the value held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the program counter) |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address of the data access (ALU result) |
| dmem_wdata | output | 32 | Store data, taken from R[rt] |
| dmem_we | output | 1 | Data write strobe, acted on at the clock edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The register file is written at the same clock edge at which its old content is still being read. An `add r1, r1, r1` therefore reads and replaces r1 in a single cycle. The bench checks, through a following store, that the doubled old value lands in memory and not a value that fed back on itself. A taken branch and a jump each skip stores whose memory words hold known preset patterns. The bench also tracks the program counter so it can show that the skipped addresses were never fetched.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RFMT = 6'b000000;
  localparam logic [5:0] OP_ORI  = 6'b001101;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BREQ = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_SUB  = 6'b100010;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    ext_sign;
    logic    wb_mem;
    logic    mem_wr;
    logic    reg_wr;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] ext16(input logic [15:0] imm, input logic sgn);
    return {{(XLEN-16){sgn & imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input alu_op_e op);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] pc_next(input logic [XLEN-1:0] pc4,
                                              input logic [15:0] off,
                                              input logic [25:0] tgt,
                                              input logic take,
                                              input logic jmp);
    logic [XLEN-1:0] disp;
    disp = ext16(off, 1'b1) << 2;
    if (jmp)       return {pc4[XLEN-1:28], tgt, 2'b00};
    else if (take) return pc4 + disp;
    else           return pc4;
  endfunction
endpackage

// File: rtl/sc_core_ctrl.sv
module sc_core_ctrl
  import sc_core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] fn,
  output ctrl_t      ctl,
  output logic       known
);
  always_comb begin
    ctl   = '0;
    known = 1'b1;
    case (op)
      OP_RFMT: begin
        ctl.dst_rd = 1'b1;
        if (fn == FN_ADD) begin
          ctl.reg_wr = 1'b1;
          ctl.alu_op = ALU_ADD;
        end else if (fn == FN_SUB) begin
          ctl.reg_wr = 1'b1;
          ctl.alu_op = ALU_SUB;
        end else begin
          known = 1'b0;
        end
      end
      OP_ORI: begin
        ctl.src_imm = 1'b1;
        ctl.reg_wr  = 1'b1;
        ctl.alu_op  = ALU_OR;
      end
      OP_LOAD: begin
        ctl.src_imm  = 1'b1;
        ctl.ext_sign = 1'b1;
        ctl.wb_mem   = 1'b1;
        ctl.reg_wr   = 1'b1;
        ctl.alu_op   = ALU_ADD;
      end
      OP_STOR: begin
        ctl.src_imm  = 1'b1;
        ctl.ext_sign = 1'b1;
        ctl.mem_wr   = 1'b1;
        ctl.alu_op   = ALU_ADD;
      end
      OP_BREQ: begin
        ctl.ext_sign = 1'b1;
        ctl.branch   = 1'b1;
        ctl.alu_op   = ALU_SUB;
      end
      OP_JMP:  ctl.jump = 1'b1;
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_core_regs.sv
module sc_core_regs #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] bank [DEPTH];

  always_ff @(posedge clk) begin
    if (we && wa != '0) bank[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : bank[ra];
  assign qb = (rb == '0) ? '0 : bank[rb];
endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_calc(a, b, op);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  logic [XLEN-1:0] pc_q, pc_plus4, pc_nxt;
  logic [XLEN-1:0] rd_a, rd_b, imm_x, alu_b, alu_y, wb_data;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, wr_idx;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;
  ctrl_t           ctl;
  logic            op_known, alu_zero, br_taken, reg_we;

  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_imm = imem_rdata[15:0];
  assign f_tgt = imem_rdata[25:0];

  sc_core_ctrl u_ctrl (
    .op(imem_rdata[31:26]), .fn(imem_rdata[5:0]), .ctl(ctl), .known(op_known)
  );

  assign wr_idx  = ctl.dst_rd ? f_rd : f_rt;
  assign reg_we  = ctl.reg_wr & ~rst;
  assign wb_data = ctl.wb_mem ? dmem_rdata : alu_y;

  sc_core_regs #(.W(XLEN), .AW(RIDX)) u_regs (
    .clk(clk), .we(reg_we), .wa(wr_idx), .wd(wb_data),
    .ra(f_rs), .rb(f_rt), .qa(rd_a), .qb(rd_b)
  );

  assign imm_x = ext16(f_imm, ctl.ext_sign);
  assign alu_b = ctl.src_imm ? imm_x : rd_b;

  sc_core_alu u_alu (
    .a(rd_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  assign br_taken = ctl.branch & alu_zero;
  assign pc_plus4 = pc_q + 32'd4;
  assign pc_nxt   = pc_next(pc_plus4, f_imm, f_tgt, br_taken, ctl.jump);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rd_b;
  assign dmem_we    = ctl.mem_wr & ~rst;

  // R1: reset clears the program counter and blocks memory writes
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc_q == '0));
  a_r1_reset_nowr: assert property (@(posedge clk) rst |-> (!dmem_we && !reg_we));
  // R2: sequential flow
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));
  // R6: a store never writes the register file
  a_r6_store_noreg: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !reg_we);
  // R7: taken branch target
  a_r7_branch_tgt: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(pc_plus4 + {{14{f_imm[15]}}, f_imm, 2'b00})));
  // R8: jump target
  a_r8_jump_tgt: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pc_q == {$past(pc_plus4[31:28]), $past(f_tgt), 2'b00}));
  // R10: unknown encodings act as no-ops
  a_r10_unknown_noop: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!reg_we && !dmem_we && !ctl.branch && !ctl.jump));
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  int          n_chk = 0;
  int          n_fail = 0;
  int          hits_br_skip = 0;
  int          hits_j_skip = 0;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  always #4 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(negedge clk) if (!rst) begin
    if (imem_addr == 32'd64 || imem_addr == 32'd68) hits_br_skip++;
    if (imem_addr == 32'd84 || imem_addr == 32'd88) hits_j_skip++;
  end

  function automatic logic [31:0] e_r(int s, int t, int d, logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] e_i(logic [5:0] op, int s, int t, logic [15:0] imm);
    return {op, 5'(s), 5'(t), imm};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  typedef struct packed { logic [5:0] word; logic [31:0] val; } mem_exp_t;
  localparam mem_exp_t EXP [14] = '{
    '{6'd0,  32'h0001_0004},  // R3 add
    '{6'd1,  32'hFFFF_0006},  // R3 sub
    '{6'd2,  32'h0000_FFFF},  // R4 zero extension
    '{6'd3,  32'hCAFE_F00D},  // R5 load
    '{6'd4,  32'h0000_0000},  // R9 r0 stays zero
    '{6'd19, 32'h0000_0005},  // R6 negative offset
    '{6'd5,  32'h0000_0005},  // R7 branch not taken
    '{6'd6,  32'h1111_1111},  // R7 skipped store
    '{6'd7,  32'h2222_2222},  // R7 skipped store
    '{6'd8,  32'h0000_0005},  // R10 unknown opcode
    '{6'd9,  32'h3333_3333},  // R8 skipped by jump
    '{6'd10, 32'h0001_0004},  // R8 jump target ran
    '{6'd11, 32'h0000_000A},  // R11 read before write
    '{6'd16, 32'hCAFE_F00D}   // R5 load leaves memory
  };

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    dmem[4] = 32'h4444_4444; dmem[6] = 32'h1111_1111; dmem[7] = 32'h2222_2222;
    dmem[9] = 32'h3333_3333; dmem[16] = 32'hCAFE_F00D;
    imem[0]  = e_i(6'b001101, 0, 1, 16'h0005);
    imem[1]  = e_i(6'b001101, 0, 2, 16'hFFFF);
    imem[2]  = e_r(1, 2, 3, 6'b100000);
    imem[3]  = e_r(1, 2, 4, 6'b100010);
    imem[4]  = e_i(6'b101011, 0, 3, 16'd0);
    imem[5]  = e_i(6'b101011, 0, 4, 16'd4);
    imem[6]  = e_i(6'b101011, 0, 2, 16'd8);
    imem[7]  = e_i(6'b100011, 0, 5, 16'h0040);
    imem[8]  = e_i(6'b101011, 0, 5, 16'd12);
    imem[9]  = e_i(6'b001101, 0, 0, 16'h0007);
    imem[10] = e_i(6'b101011, 0, 0, 16'd16);
    imem[11] = e_i(6'b001101, 0, 6, 16'h0050);
    imem[12] = e_i(6'b101011, 6, 1, 16'hFFFC);
    imem[13] = e_i(6'b000100, 1, 2, 16'd5);
    imem[14] = e_i(6'b101011, 0, 1, 16'd20);
    imem[15] = e_i(6'b000100, 1, 1, 16'd2);
    imem[16] = e_i(6'b101011, 0, 1, 16'd24);
    imem[17] = e_i(6'b101011, 0, 1, 16'd28);
    imem[18] = e_i(6'b111111, 0, 1, 16'h1234);
    imem[19] = e_i(6'b101011, 0, 1, 16'd32);
    imem[20] = {6'b000010, 26'd23};
    imem[21] = e_i(6'b101011, 0, 1, 16'd36);
    imem[22] = e_i(6'b101011, 0, 1, 16'd36);
    imem[23] = e_i(6'b101011, 0, 3, 16'd40);
    imem[24] = e_r(1, 1, 1, 6'b100000);
    imem[25] = e_i(6'b101011, 0, 1, 16'd44);
    imem[26] = e_i(6'b000100, 0, 0, 16'hFFFF);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'd0, "R1 reset pc", imem_addr, 32'd0);
    check(!dmem_we, "R1 no write in reset", {31'd0, dmem_we}, 32'd0);
    check(dmem[0] == 32'h0, "R1 memory untouched", dmem[0], 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(imem_addr == 32'd4, "R2 pc step", imem_addr, 32'd4);
    repeat (40) @(negedge clk);
    check(imem_addr == 32'd104, "R7 backward branch self loop", imem_addr, 32'd104);
    @(negedge clk);
    check(imem_addr == 32'd104, "R7 loop holds", imem_addr, 32'd104);
    check(hits_br_skip == 0, "R7 skipped fetch", 32'(hits_br_skip), 32'd0);
    check(hits_j_skip == 0, "R8 skipped fetch", 32'(hits_j_skip), 32'd0);
    for (int k = 0; k < 14; k++)
      check(dmem[EXP[k].word] == EXP[k].val, "memory table R3-group entry",
            dmem[EXP[k].word], EXP[k].val);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", imem_addr, 32'd104);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule